// File: doc/BRIEF.md
# Associative Memory Access Decoder

This block sits at the front of a cascadable associative memory device. On every clock edge where the cycle strobe is high, it samples the control pins: two active-low chip selects, write enable, address-valid, data-segment control, the address/control bus and the data bus. It decides whether the device is selected. It then classifies the cycle as a random memory access, a register access, a compare or nothing. The result appears one clock later as a one-hot cycle-kind vector, a one-hot register select and a direct-address flag. The memory array and the compare engine use these outputs. They are not part of this block.

The block holds three registers itself, because it needs them to decode later cycles:

- **Configuration register:** page address, mask choice and control-mode bit.
- **Device-select register:** value and active-low enable.
- **Instruction register.**

A three-state machine tracks the control mode:

- `ST_HW` is hardware control. Commands arrive on the address/control bus, and address-valid low means a direct memory address.
- `ST_SW_IDLE` is software control with no instruction loaded yet.
- `ST_SW_ARMED` is software control with an instruction loaded.

The transitions are:

- `to_sw`: a configuration write with the mode bit set enters `ST_SW_IDLE`, from any state.
- `to_hw`: a configuration write with the mode bit clear enters `ST_HW`.
- `arm`: an instruction-register write in either software state enters `ST_SW_ARMED`.

In software control, address-valid separates instruction words from data words. Memory is then reachable only indirectly, through the address register.

Top module: `amad_top`

## Requirements
- R1: After reset the cycle kind is NONE, the register select is zero, the page address and mask choice are zero, the block is in hardware mode and not armed, and the address and segment outputs are zero. The device-select enable resets to high, which means disabled.
- R2: Each clock, `kind_o` has exactly one bit set. The bit positions are NONE=0, MEM_RD=1, MEM_WR=2, REG_RD=3, REG_WR=4, CMP=5. The outputs reflect the cycle sampled at the previous edge. A clock with the strobe low, or a deselected strobed cycle, gives NONE.
- R3: A strobed cycle is decoded when `cs1_n` is low or when `cs2_n` is low. With both high and no device-select match, it gives NONE.
- R4: The device is also selected when the device-select register's enable bit (`dq[PW]` on write) is low and its value (`dq[PW-1:0]` on write) equals the page address. The device-select register is register index 11.
- R5: In hardware mode with `av_n` low, the cycle is a direct memory access: MEM_RD when `we_n` is high and MEM_WR when it is low. `direct_o` is 1 and `addr_o` holds the sampled `ac`.
- R6: In hardware mode with `av_n` high, `ac[5:4]` is the operation and `ac[3:0]` is the register index. The operations decode as follows:
  - 0 is a register access: REG_RD when `we_n` is high, REG_WR when it is low, with `regsel_o` one-hot at the index. Indices run from 0 (comparand), through 1..7 (masks), 8 (configuration), 9 (status), 10 (address) and 11 (device select), to 12 (instruction). An index above 12 gives NONE.
  - 1 is a compare.
  - 2 is an indirect memory access: MEM_RD or MEM_WR by `we_n`, with `direct_o` 0.
  - 3 gives NONE.
- R7: A configuration write loads the page from `dq[PW-1:0]`, the mask choice from `dq[PW+2:PW]` and the software-mode bit from `dq[PW+3]`. The new values are visible on `page_o`, `maskch_o` and `swmode_o` the next clock.
- R8: In software mode with `av_n` high, `we_n` low writes `dq[5:0]` into the instruction register, reported as REG_WR with select 12. `we_n` high reads status, reported as REG_RD with select 9. The first instruction write sets `armed_o`.
- R9: In software mode, a data cycle (`av_n` low) before any instruction is loaded gives NONE.
- R10: In software mode, an armed data cycle executes the instruction with the same operation and index encoding as R6, with `we_n` choosing read or write. `direct_o` is never 1 for a cycle decoded in software mode.
- R11: A configuration write with the mode bit clear returns the block to hardware mode, where direct addressing works again.
- R12: `seg_o` takes `dsc` on every selected strobed cycle and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | Cycle strobe; pins are sampled when high |
| cs1_n | input | 1 | Chip select one, active low |
| cs2_n | input | 1 | Chip select two, active low |
| we_n | input | 1 | Write enable, active low |
| av_n | input | 1 | Address-valid (hardware) or data/instruction marker (software) |
| dsc | input | 1 | Data-segment control |
| ac | input | ACW | Address/control bus |
| dq | input | PW+4 | Data bus word used for register loads |
| kind_o | output | 6 | One-hot cycle kind |
| regsel_o | output | 13 | One-hot register select for register cycles |
| direct_o | output | 1 | Memory access uses the direct address |
| addr_o | output | ACW | Direct memory address |
| seg_o | output | 1 | Latched data-segment control |
| page_o | output | PW | Configured page address |
| maskch_o | output | 3 | Mask choice for direct writes (0 = none) |
| swmode_o | output | 1 | Software control mode |
| armed_o | output | 1 | Instruction loaded in software mode |

## Verification
The checker watches the following on every clock:

- The cycle-kind vector stays one-hot.
- An idle strobe yields NONE.
- Register selects appear only on register cycles.
- Direct hardware reads carry the sampled address.
- Software-mode cycles never flag direct addressing.
- Unarmed software data cycles do nothing.
- The segment bit follows a selected strobe.

Selection through the device-select register, the configuration fields, the mode transitions and the behaviour after a reset pulse all depend on register contents built up over several cycles. Only the bench's ordered scenarios show them.

// File: rtl/amad_pkg.sv
package amad_pkg;

    localparam int NKIND = 6;
    localparam int NREG  = 13;
    localparam int RIW   = 4;
    localparam int CW    = 6;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_MRD  = 3'd1,
        K_MWR  = 3'd2,
        K_RRD  = 3'd3,
        K_RWR  = 3'd4,
        K_CMP  = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        OP_REG = 2'd0,
        OP_CMP = 2'd1,
        OP_MEM = 2'd2,
        OP_NOP = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_HW       = 2'd0,
        ST_SW_IDLE  = 2'd1,
        ST_SW_ARMED = 2'd2
    } mode_st_e;

    localparam logic [RIW-1:0] REG_CMPND = 4'd0;
    localparam logic [RIW-1:0] REG_CFG   = 4'd8;
    localparam logic [RIW-1:0] REG_STAT  = 4'd9;
    localparam logic [RIW-1:0] REG_ADDR  = 4'd10;
    localparam logic [RIW-1:0] REG_DSEL  = 4'd11;
    localparam logic [RIW-1:0] REG_INSTR = 4'd12;

endpackage

// File: rtl/amad_sel.sv
module amad_sel #(
    parameter int PW = 6
) (
    input  logic          cs1_n,
    input  logic          cs2_n,
    input  logic [PW-1:0] dsel_val,
    input  logic          dsel_en_n,
    input  logic [PW-1:0] page,
    output logic          selected
);
    logic pin_hit;
    logic reg_hit;

    always_comb begin
        pin_hit  = !cs1_n || !cs2_n;
        reg_hit  = !dsel_en_n && (dsel_val == page);
        selected = pin_hit || reg_hit;
    end
endmodule

// File: rtl/amad_codec.sv
module amad_codec
    import amad_pkg::*;
(
    input  logic [CW-1:0]  code,
    input  logic           we_n,
    output kind_e          kind,
    output logic [RIW-1:0] ridx
);
    op_e op;

    always_comb begin
        op   = op_e'(code[5:4]);
        ridx = code[3:0];
        kind = K_NONE;
        unique case (op)
            OP_REG: begin
                if (code[3:0] < RIW'(NREG)) begin
                    kind = we_n ? K_RRD : K_RWR;
                end
            end
            OP_CMP: kind = K_CMP;
            OP_MEM: kind = we_n ? K_MRD : K_MWR;
            OP_NOP: kind = K_NONE;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/amad_onehot.sv
module amad_onehot #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [IW-1:0] idx,
    input  logic          en,
    output logic [N-1:0]  vec
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign vec[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/amad_regs.sv
module amad_regs
    import amad_pkg::*;
#(
    parameter int PW = 6,
    localparam int DQW = PW + 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_cfg,
    input  logic           wr_dsel,
    input  logic           wr_instr,
    input  logic [DQW-1:0] dq,
    output logic [PW-1:0]  page,
    output logic [2:0]     maskch,
    output logic           swbit,
    output logic [PW-1:0]  dsel_val,
    output logic           dsel_en_n,
    output logic [CW-1:0]  instr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page   <= '0;
            maskch <= '0;
            swbit  <= 1'b0;
        end else if (wr_cfg) begin
            page   <= dq[PW-1:0];
            maskch <= dq[PW+2:PW];
            swbit  <= dq[PW+3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsel_val  <= '0;
            dsel_en_n <= 1'b1;
        end else if (wr_dsel) begin
            dsel_val  <= dq[PW-1:0];
            dsel_en_n <= dq[PW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr <= '0;
        end else if (wr_instr) begin
            instr <= dq[CW-1:0];
        end
    end
endmodule

// File: rtl/amad_top.sv
module amad_top
    import amad_pkg::*;
#(
    parameter int ACW = 8,
    parameter int PW  = 6,
    localparam int DQW = PW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_stb,
    input  logic            cs1_n,
    input  logic            cs2_n,
    input  logic            we_n,
    input  logic            av_n,
    input  logic            dsc,
    input  logic [ACW-1:0]  ac,
    input  logic [DQW-1:0]  dq,
    output logic [NKIND-1:0] kind_o,
    output logic [NREG-1:0] regsel_o,
    output logic            direct_o,
    output logic [ACW-1:0]  addr_o,
    output logic            seg_o,
    output logic [PW-1:0]   page_o,
    output logic [2:0]      maskch_o,
    output logic            swmode_o,
    output logic            armed_o
);
    mode_st_e state, state_nx;

    logic           selected;
    logic [PW-1:0]  dsel_val;
    logic           dsel_en_n;
    logic [CW-1:0]  instr;
    logic           swbit;
    logic [CW-1:0]  code_mux;
    kind_e          c_kind;
    logic [RIW-1:0] c_ridx;

    kind_e          d_kind;
    logic [RIW-1:0] d_ridx;
    logic           d_direct;
    logic           d_take;
    logic           d_is_reg;
    logic           wr_cfg, wr_dsel, wr_instr;
    logic [NKIND-1:0] kind_vec;
    logic [NREG-1:0]  sel_vec;

    amad_regs #(.PW(PW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (wr_cfg),
        .wr_dsel  (wr_dsel),
        .wr_instr (wr_instr),
        .dq       (dq),
        .page     (page_o),
        .maskch   (maskch_o),
        .swbit    (swbit),
        .dsel_val (dsel_val),
        .dsel_en_n(dsel_en_n),
        .instr    (instr)
    );

    amad_sel #(.PW(PW)) u_sel (
        .cs1_n    (cs1_n),
        .cs2_n    (cs2_n),
        .dsel_val (dsel_val),
        .dsel_en_n(dsel_en_n),
        .page     (page_o),
        .selected (selected)
    );

    assign code_mux = (state == ST_HW) ? ac[CW-1:0] : instr;

    amad_codec u_codec (
        .code (code_mux),
        .we_n (we_n),
        .kind (c_kind),
        .ridx (c_ridx)
    );

    // cycle classification for the current sampled pins
    always_comb begin
        d_kind   = K_NONE;
        d_ridx   = '0;
        d_direct = 1'b0;
        d_take   = cyc_stb && selected;
        if (d_take) begin
            unique case (state)
                ST_HW: begin
                    if (!av_n) begin
                        d_kind   = we_n ? K_MRD : K_MWR;
                        d_direct = 1'b1;
                    end else begin
                        d_kind = c_kind;
                        d_ridx = c_ridx;
                    end
                end
                ST_SW_IDLE: begin
                    if (av_n) begin
                        d_kind = we_n ? K_RRD : K_RWR;
                        d_ridx = we_n ? REG_STAT : REG_INSTR;
                    end
                end
                ST_SW_ARMED: begin
                    if (av_n) begin
                        d_kind = we_n ? K_RRD : K_RWR;
                        d_ridx = we_n ? REG_STAT : REG_INSTR;
                    end else begin
                        d_kind = c_kind;
                        d_ridx = c_ridx;
                    end
                end
                default: d_kind = K_NONE;
            endcase
        end
        d_is_reg = (d_kind == K_RRD) || (d_kind == K_RWR);
        wr_cfg   = (d_kind == K_RWR) && (d_ridx == REG_CFG);
        wr_dsel  = (d_kind == K_RWR) && (d_ridx == REG_DSEL);
        wr_instr = (d_kind == K_RWR) && (d_ridx == REG_INSTR);
    end

    // mode transitions: to_sw, to_hw, arm
    always_comb begin
        state_nx = state;
        if (wr_cfg) begin
            state_nx = dq[PW+3] ? ST_SW_IDLE : ST_HW;
        end else if (wr_instr) begin
            unique case (state)
                ST_HW:       state_nx = ST_HW;
                ST_SW_IDLE:  state_nx = ST_SW_ARMED;
                ST_SW_ARMED: state_nx = ST_SW_ARMED;
                default:     state_nx = ST_HW;
            endcase
        end
    end

    amad_onehot #(.N(NKIND), .IW(3)) u_kind_oh (
        .idx (d_kind),
        .en  (1'b1),
        .vec (kind_vec)
    );

    amad_onehot #(.N(NREG), .IW(RIW)) u_reg_oh (
        .idx (d_ridx),
        .en  (d_is_reg),
        .vec (sel_vec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HW;
        end else begin
            state <= state_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_o   <= NKIND'(1);
            regsel_o <= '0;
            direct_o <= 1'b0;
            addr_o   <= '0;
            seg_o    <= 1'b0;
        end else begin
            kind_o   <= kind_vec;
            regsel_o <= sel_vec;
            direct_o <= d_direct;
            if (d_direct) begin
                addr_o <= ac;
            end
            if (d_take) begin
                seg_o <= dsc;
            end
        end
    end

    assign swmode_o = swbit;
    assign armed_o  = (state == ST_SW_ARMED);

endmodule

// File: rtl/amad_chk.sv
module amad_chk #(
    parameter int ACW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cyc_stb,
    input logic           cs1_n,
    input logic           we_n,
    input logic           av_n,
    input logic           dsc,
    input logic [ACW-1:0] ac,
    input logic [5:0]     kind_o,
    input logic [12:0]    regsel_o,
    input logic           direct_o,
    input logic [ACW-1:0] addr_o,
    input logic           seg_o,
    input logic           swmode_o,
    input logic           armed_o
);
    assert_kind_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(kind_o) == 1);

    assert_idle_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> kind_o == 6'b000001);

    assert_regsel_only_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        regsel_o != 13'd0 |-> ((kind_o[3] || kind_o[4]) && $onehot0(regsel_o)));

    assert_direct_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !cs1_n && !av_n && we_n && !swmode_o)
        |=> (kind_o == 6'b000010 && direct_o && addr_o == $past(ac)));

    assert_sw_no_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && swmode_o) |=> !direct_o);

    assert_unarmed_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && swmode_o && !armed_o && !av_n) |=> kind_o == 6'b000001);

    assert_seg_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !cs1_n) |=> seg_o == $past(dsc));
endmodule

bind amad_top amad_chk #(.ACW(ACW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_stb  (cyc_stb),
    .cs1_n    (cs1_n),
    .we_n     (we_n),
    .av_n     (av_n),
    .dsc      (dsc),
    .ac       (ac),
    .kind_o   (kind_o),
    .regsel_o (regsel_o),
    .direct_o (direct_o),
    .addr_o   (addr_o),
    .seg_o    (seg_o),
    .swmode_o (swmode_o),
    .armed_o  (armed_o)
);

// File: tb/sim_amad_top.sv
`timescale 1ns/1ps
module sim_amad_top;
    localparam int ACW = 8;
    localparam int PW  = 6;
    localparam int DQW = PW + 4;
    localparam int VW  = 44;

    localparam logic [5:0] KN = 6'b000001;
    localparam logic [5:0] KR = 6'b000010;
    localparam logic [5:0] KW = 6'b000100;
    localparam logic [5:0] RR = 6'b001000;
    localparam logic [5:0] RW = 6'b010000;
    localparam logic [5:0] KC = 6'b100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0, cs1_n = 1'b1, cs2_n = 1'b1, we_n = 1'b1, av_n = 1'b1, dsc = 1'b0;
    logic [ACW-1:0] ac = '0;
    logic [DQW-1:0] dq = '0;
    logic [5:0]  kind_o;
    logic [12:0] regsel_o;
    logic direct_o, seg_o, swmode_o, armed_o;
    logic [ACW-1:0] addr_o;
    logic [PW-1:0]  page_o;
    logic [2:0]     maskch_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    amad_top #(.ACW(ACW), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cs1_n(cs1_n), .cs2_n(cs2_n),
        .we_n(we_n), .av_n(av_n), .dsc(dsc), .ac(ac), .dq(dq),
        .kind_o(kind_o), .regsel_o(regsel_o), .direct_o(direct_o), .addr_o(addr_o),
        .seg_o(seg_o), .page_o(page_o), .maskch_o(maskch_o), .swmode_o(swmode_o),
        .armed_o(armed_o)
    );

    function automatic logic [VW-1:0] V(input logic stb, input logic c1, input logic c2,
                                        input logic w, input logic a, input logic [7:0] acv,
                                        input logic [9:0] dqv, input logic [5:0] k,
                                        input logic [12:0] s, input logic d);
        return {stb, c1, c2, w, a, 1'b0, acv, dqv, k, s, d};
    endfunction

    localparam int NV = 29;
    localparam logic [VW-1:0] TBL [0:NV-1] = '{
        V(0,0,0,1,0, 8'h00, 10'h000, KN, 13'd0, 0),          // R2 no strobe
        V(1,1,1,1,0, 8'h00, 10'h000, KN, 13'd0, 0),          // R3 deselected
        V(1,0,1,1,0, 8'h5A, 10'h000, KR, 13'd0, 1),          // R5 direct read, cs1
        V(1,1,0,0,0, 8'h33, 10'h000, KW, 13'd0, 1),          // R3 R5 direct write, cs2
        V(1,0,1,1,1, 8'h03, 10'h000, RR, 13'd1 << 3, 0),     // R6 mask read
        V(1,0,1,0,1, 8'h00, 10'h000, RW, 13'd1 << 0, 0),     // R6 comparand write
        V(1,0,1,1,1, 8'h10, 10'h000, KC, 13'd0, 0),          // R6 compare
        V(1,0,1,1,1, 8'h20, 10'h000, KR, 13'd0, 0),          // R6 indirect read
        V(1,0,1,1,1, 8'h30, 10'h000, KN, 13'd0, 0),          // R6 no-op code
        V(1,0,1,1,1, 8'h0D, 10'h000, KN, 13'd0, 0),          // R6 index 13 invalid
        V(1,0,1,0,1, 8'h0B, 10'h000, RW, 13'd1 << 11, 0),    // R4 devsel val 0 enabled
        V(1,1,1,1,0, 8'h44, 10'h000, KR, 13'd0, 1),          // R4 selected by devsel
        V(1,0,1,0,1, 8'h08, 10'h005, RW, 13'd1 << 8, 0),     // R7 page 5
        V(1,1,1,1,0, 8'h44, 10'h000, KN, 13'd0, 0),          // R4 mismatch
        V(1,0,1,0,1, 8'h0B, 10'h005, RW, 13'd1 << 11, 0),    // R4 devsel val 5
        V(1,1,1,1,0, 8'h44, 10'h000, KR, 13'd0, 1),          // R4 match again
        V(1,0,1,0,1, 8'h0B, 10'h045, RW, 13'd1 << 11, 0),    // R4 enable bit high
        V(1,1,1,1,0, 8'h44, 10'h000, KN, 13'd0, 0),          // R4 disabled
        V(1,0,1,0,1, 8'h08, 10'h2C5, RW, 13'd1 << 8, 0),     // R7 enter software mode
        V(1,0,1,1,0, 8'hFF, 10'h000, KN, 13'd0, 0),          // R9 unarmed data
        V(1,0,1,1,1, 8'h00, 10'h000, RR, 13'd1 << 9, 0),     // R8 status read
        V(1,0,1,0,1, 8'h00, 10'h020, RW, 13'd1 << 12, 0),    // R8 instr = mem op
        V(1,0,1,1,0, 8'hFF, 10'h000, KR, 13'd0, 0),          // R10 indirect read
        V(1,0,1,0,0, 8'hFF, 10'h000, KW, 13'd0, 0),          // R10 indirect write
        V(1,0,1,0,1, 8'h00, 10'h010, RW, 13'd1 << 12, 0),    // R8 instr = compare
        V(1,0,1,1,0, 8'h00, 10'h000, KC, 13'd0, 0),          // R10 compare
        V(1,0,1,0,1, 8'h00, 10'h008, RW, 13'd1 << 12, 0),    // R8 instr = config reg
        V(1,0,1,0,0, 8'h00, 10'h000, RW, 13'd1 << 8, 0),     // R11 write config, hw
        V(1,0,1,1,0, 8'h77, 10'h000, KR, 13'd0, 1)           // R11 direct read again
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic stb, input logic c1, input logic c2, input logic w,
                         input logic a, input logic ds, input logic [7:0] acv,
                         input logic [9:0] dqv);
        cyc_stb = stb; cs1_n = c1; cs2_n = c2; we_n = w; av_n = a; dsc = ds;
        ac = acv; dq = dqv;
        @(posedge clk);
        @(negedge clk);
        cyc_stb = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 kind", 32'(kind_o), 32'(KN));
        check("R1 regsel", 32'(regsel_o), 32'd0);
        check("R1 page", 32'(page_o), 32'd0);
        check("R1 swmode", 32'(swmode_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = TBL[i];
            drive(v[43], v[42], v[41], v[40], v[39], v[38], v[37:30], v[29:20]);
            check($sformatf("vec %0d kind", i), 32'(kind_o), 32'(v[19:14]));
            check($sformatf("vec %0d regsel", i), 32'(regsel_o), 32'(v[13:1]));
            check($sformatf("vec %0d direct", i), 32'(direct_o), 32'(v[0]));
        end

        // R7 configuration fields
        drive(1, 0, 1, 0, 1, 0, 8'h08, 10'h1EA);
        check("R7 page", 32'(page_o), 32'd42);
        check("R7 maskch", 32'(maskch_o), 32'd7);
        check("R7 swmode", 32'(swmode_o), 32'd0);

        // R5 R12 direct write with address and segment
        drive(1, 0, 1, 0, 0, 1, 8'hA5, 10'h000);
        check("R5 kind", 32'(kind_o), 32'(KW));
        check("R5 addr", 32'(addr_o), 32'hA5);
        check("R12 seg", 32'(seg_o), 32'd1);

        // R12 unstrobed dsc has no effect
        drive(0, 0, 1, 1, 0, 0, 8'h11, 10'h000);
        check("R12 seg hold", 32'(seg_o), 32'd1);
        check("R5 addr hold", 32'(addr_o), 32'hA5);

        // R7 R8 software mode and arming
        drive(1, 0, 1, 0, 1, 0, 8'h08, 10'h200);
        check("R7 swmode set", 32'(swmode_o), 32'd1);
        check("R8 not armed", 32'(armed_o), 32'd0);
        drive(1, 0, 1, 0, 1, 0, 8'h00, 10'h020);
        check("R8 armed", 32'(armed_o), 32'd1);

        // R1 reset pulse mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 kind after reset", 32'(kind_o), 32'(KN));
        check("R1 swmode after reset", 32'(swmode_o), 32'd0);
        check("R1 armed after reset", 32'(armed_o), 32'd0);
        check("R1 page after reset", 32'(page_o), 32'd0);
        check("R1 mask after reset", 32'(maskch_o), 32'd0);
        check("R1 addr after reset", 32'(addr_o), 32'd0);
        check("R1 seg after reset", 32'(seg_o), 32'd0);

        // R4 devsel disabled after reset: deselected cycle gives nothing
        drive(1, 1, 1, 1, 0, 0, 8'h01, 10'h000);
        check("R4 devsel reset disabled", 32'(kind_o), 32'(KN));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule